// File: doc/BRIEF.md
# Parity-Protected Dynamic Memory Controller with Idle Refresh

This controller sits between a processor and a slow dynamic memory of 512 words. Every stored word is 18 bits wide: 16 data bits and one even-parity bit for each data byte. Each bitplane of the storage is arranged as 8 rows by 64 columns. The controller drives one-hot row and column selects, a write strobe and an 18-bit write word toward the array, and it takes the addressed 18-bit word back on a read bus.

Processor requests come in on a valid/ready interface with an address, a write flag and 16 bits of write data. A write stores the data together with freshly generated parity. A read returns the data one cycle after it is accepted, with a flag that reports a parity mismatch. The data are returned even when the flag is set. Reading a dynamic cell destroys its charge, so every read access also writes the word back. In any cycle without a processor request, the controller refreshes the next location from a counter that walks through all 512 words. It pulses a wrap signal when a full pass is complete.

Top module: `parity_dram_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `reqReady`, `rspValid`, `rspParErr`, `memWrStrobe` and every row and column select are 0. From the second cycle after release, `reqReady` is 1.
- R2: An access to address A drives exactly one row select, bit A[2:0], and exactly one column select, bit A[8:3], in the same cycle that the access is presented.
- R3: An accepted write drives `memWrStrobe`=1 in the same cycle. It also drives `memWdata[15:0]` with the write data, `memWdata[16]` with the XOR of data bits 7..0 and `memWdata[17]` with the XOR of data bits 15..8, which gives even parity per byte.
- R4: An accepted read presents the stored data bits 15..0 on `rspData`, with `rspValid`=1, in the cycle after acceptance. `rspValid` is 0 in every cycle that does not follow an accepted read.
- R5: `rspParErr` is 1, together with `rspValid`, exactly when the word read has odd parity in at least one byte. Byte 0 covers bits 7..0 plus bit 16, and byte 1 covers bits 15..8 plus bit 17. The data are returned unchanged in either case.
- R6: An accepted read writes the word back in its own access: `memWrStrobe` is 1 and `memWdata` equals the 18-bit word on `memRdata`.
- R7: In every cycle when `reqReady`=1 and `reqValid`=0, the controller refreshes the location held in its refresh counter. It selects that address, asserts `memWrStrobe` and writes back `memRdata` unchanged. The counter starts at 0 after reset and advances by one, modulo 512, after each refresh.
- R8: A request always wins over refresh. In a cycle with a request, no refresh takes place and the refresh counter keeps its value.
- R9: `refreshWrap` is 1 only in a refresh cycle whose address is 511. Each pass of 512 refresh cycles raises it once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Processor request present |
| reqReady | output | 1 | Controller accepts requests |
| reqAddr | input | 9 | Word address (row in low 3 bits, column in high 6 bits) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 16 | Write data |
| rspValid | output | 1 | Read data valid, one cycle after the read |
| rspData | output | 16 | Read data |
| rspParErr | output | 1 | Parity mismatch on the returned word |
| memRowSel | output | 8 | One-hot row select |
| memColSel | output | 64 | One-hot column select |
| memWrStrobe | output | 1 | Write (or restore) the selected word |
| memWdata | output | 18 | Word written to the array: {parity1, parity0, data} |
| memRdata | input | 18 | Word currently stored at the selected location |
| refreshWrap | output | 1 | Refresh of the last location of a pass |

## Verification
The bench injects single-bit faults into data bits and into a stored parity bit. A checker that did not fold the parity bit into its comparison, or that compared against the wrong byte, would miss these faults. It also flips two bits of one byte, a fault that must go unreported; a checker that flagged it would not be computing even parity. Long bursts of back-to-back requests check that refresh stalls without losing its place, since a counter that advanced under a request would skip locations. Full idle passes check that the wrap pulse lands only on address 511 and that every location is restored unchanged. Reads that follow a write to the same address in the next cycle check the one-cycle response timing and show that the write-back of a destructive read does not corrupt the word.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  // Strobes from the control block to the datapath
  typedef struct packed {
    logic access;     // the array is being driven this cycle
    logic fromReq;    // address comes from the processor, not the refresh counter
    logic wrData;     // write new data with fresh parity
    logic captureRd;  // capture read data for the response
  } pdc_strobe_t;
endpackage

// File: rtl/pdc_onehot.sv
module pdc_onehot #(
  parameter int IN_W = 3
) (
  input  logic [IN_W-1:0]      code,
  input  logic                 en,
  output logic [(1<<IN_W)-1:0] sel
);
  localparam int OUT_W = 1 << IN_W;

  for (genvar i = 0; i < OUT_W; i++) begin : g_sel
    assign sel[i] = en && (code == IN_W'(i));
  end

  always_comb begin
    if (en) assert_onehot_R2 : assert ($countones(sel) == 1);
  end
endmodule

// File: rtl/pdc_ctrl.sv
module pdc_ctrl
  import pdc_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  output logic              reqReady,
  output logic [ADDR_W-1:0] refAddr,
  output logic              refreshWrap,
  output pdc_strobe_t       strb
);
  logic readyQ;
  logic refreshNow;

  always_ff @(posedge clk) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= 1'b1;
  end

  assign reqReady   = readyQ;
  assign refreshNow = readyQ && !reqValid;

  always_ff @(posedge clk) begin
    if (!rstN)           refAddr <= '0;
    else if (refreshNow) refAddr <= refAddr + 1'b1;
  end

  assign refreshWrap = refreshNow && (refAddr == {ADDR_W{1'b1}});

  always_comb begin
    strb.access    = readyQ;
    strb.fromReq   = readyQ && reqValid;
    strb.wrData    = readyQ && reqValid && reqWrite;
    strb.captureRd = readyQ && reqValid && !reqWrite;
  end

  assert_hold_ref_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> $stable(refAddr));

  assert_step_ref_R7 : assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid && reqReady) |=> (refAddr == $past(refAddr) + 1'b1));

  assert_wrap_R9 : assert property (@(posedge clk) disable iff (!rstN)
    refreshWrap |=> (refAddr == '0));
endmodule

// File: rtl/pdc_datapath.sv
module pdc_datapath
  import pdc_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int BYTE_W   = 8,
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  pdc_strobe_t                 strb,
  input  logic [ROW_BITS+COL_BITS-1:0] reqAddr,
  input  logic [ROW_BITS+COL_BITS-1:0] refAddr,
  input  logic [DATA_W-1:0]           reqWdata,
  input  logic [DATA_W+DATA_W/BYTE_W-1:0] memRdata,
  output logic [(1<<ROW_BITS)-1:0]    memRowSel,
  output logic [(1<<COL_BITS)-1:0]    memColSel,
  output logic                        memWrStrobe,
  output logic [DATA_W+DATA_W/BYTE_W-1:0] memWdata,
  output logic                        rspValid,
  output logic [DATA_W-1:0]           rspData,
  output logic                        rspParErr
);
  localparam int PAR_W  = DATA_W / BYTE_W;
  localparam int WORD_W = DATA_W + PAR_W;
  localparam int ADDR_W = ROW_BITS + COL_BITS;

  logic [ADDR_W-1:0] selAddr;
  logic [PAR_W-1:0]  genPar;
  logic [PAR_W-1:0]  byteBad;

  assign selAddr = strb.fromReq ? reqAddr : refAddr;

  pdc_onehot #(.IN_W(ROW_BITS)) i_rowDec (
    .code(selAddr[ROW_BITS-1:0]), .en(strb.access), .sel(memRowSel));
  pdc_onehot #(.IN_W(COL_BITS)) i_colDec (
    .code(selAddr[ADDR_W-1:ROW_BITS]), .en(strb.access), .sel(memColSel));

  for (genvar b = 0; b < PAR_W; b++) begin : g_par
    assign genPar[b]  = ^reqWdata[b*BYTE_W +: BYTE_W];
    assign byteBad[b] = (^memRdata[b*BYTE_W +: BYTE_W]) ^ memRdata[DATA_W + b];

    assert_even_par_R3 : assert property (@(posedge clk) disable iff (!rstN)
      strb.wrData |-> ((^memWdata[b*BYTE_W +: BYTE_W]) == memWdata[DATA_W + b]));
  end

  assign memWrStrobe = strb.access;
  assign memWdata    = strb.wrData ? {genPar, reqWdata} : memRdata;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspData   <= '0;
      rspParErr <= 1'b0;
    end else begin
      rspValid  <= strb.captureRd;
      rspParErr <= strb.captureRd && (|byteBad);
      if (strb.captureRd) rspData <= memRdata[DATA_W-1:0];
    end
  end

  assert_rsp_R4 : assert property (@(posedge clk) disable iff (!rstN)
    strb.captureRd |=> rspValid);

  assert_err_valid_R5 : assert property (@(posedge clk) disable iff (!rstN)
    rspParErr |-> rspValid);

  assert_restore_R6 : assert property (@(posedge clk) disable iff (!rstN)
    strb.captureRd |-> (memWrStrobe && memWdata == memRdata));

  if (WORD_W < 2) begin : g_badw
    initial assert_word_w : assert (0);
  end
endmodule

// File: rtl/parity_dram_ctrl.sv
module parity_dram_ctrl
  import pdc_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int BYTE_W   = 8,
  parameter int ROW_BITS = 3,
  parameter int COL_BITS = 6
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         reqValid,
  output logic                         reqReady,
  input  logic [ROW_BITS+COL_BITS-1:0] reqAddr,
  input  logic                         reqWrite,
  input  logic [DATA_W-1:0]            reqWdata,
  output logic                         rspValid,
  output logic [DATA_W-1:0]            rspData,
  output logic                         rspParErr,
  output logic [(1<<ROW_BITS)-1:0]     memRowSel,
  output logic [(1<<COL_BITS)-1:0]     memColSel,
  output logic                         memWrStrobe,
  output logic [DATA_W+DATA_W/BYTE_W-1:0] memWdata,
  input  logic [DATA_W+DATA_W/BYTE_W-1:0] memRdata,
  output logic                         refreshWrap
);
  localparam int ADDR_W = ROW_BITS + COL_BITS;

  pdc_strobe_t       strb;
  logic [ADDR_W-1:0] refAddr;

  pdc_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .refAddr(refAddr), .refreshWrap(refreshWrap),
    .strb(strb));

  pdc_datapath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W),
                 .ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .refAddr(refAddr),
    .reqWdata(reqWdata), .memRdata(memRdata), .memRowSel(memRowSel),
    .memColSel(memColSel), .memWrStrobe(memWrStrobe), .memWdata(memWdata),
    .rspValid(rspValid), .rspData(rspData), .rspParErr(rspParErr));
endmodule

// File: tb/test_parity_dram_ctrl.sv
module test_parity_dram_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [8:0]  reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqWdata = '0;
  logic        rspValid;
  logic [15:0] rspData;
  logic        rspParErr;
  logic [7:0]  memRowSel;
  logic [63:0] memColSel;
  logic        memWrStrobe;
  logic [17:0] memWdata;
  logic [17:0] memRdata;
  logic        refreshWrap;

  always #(CLK_PERIOD/2) clk = ~clk;

  parity_dram_ctrl i_parity_dram_ctrl (.*);

  // Behavioural storage array
  logic [17:0] mem [512];
  int          decAddr;
  always_comb begin
    int r, c;
    r = 0; c = 0;
    for (int i = 0; i < 8; i++)  if (memRowSel[i]) r = i;
    for (int i = 0; i < 64; i++) if (memColSel[i]) c = i;
    decAddr  = c * 8 + r;
    memRdata = mem[decAddr];
  end
  always @(posedge clk) if (memWrStrobe) mem[decAddr] <= memWdata;

  int total = 0, fails = 0, wrapsSeen = 0;
  logic [8:0]  expRef = '0;
  logic        monOn = 1'b0;
  logic [16:0] rspQ [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] encode(input logic [15:0] d);
    return {^d[15:8], ^d[7:0], d};
  endfunction

  function automatic logic perr(input logic [17:0] w);
    return ((^w[7:0]) ^ w[16]) | ((^w[15:8]) ^ w[17]);
  endfunction

  // Monitor: array-side behaviour and scoreboard of responses
  always @(negedge clk) if (monOn) begin
    logic [16:0] e;
    if (reqValid) begin
      check(decAddr == int'(reqAddr), "R2 selects", decAddr, reqAddr);
      check($countones(memRowSel) == 1 && $countones(memColSel) == 1, "R2 onehot",
            $countones(memRowSel), 1);
      check(memWrStrobe, "R3/R6 strobe", memWrStrobe, 1);
      if (reqWrite) check(memWdata == encode(reqWdata), "R3 wdata", memWdata, encode(reqWdata));
      else          check(memWdata == mem[reqAddr], "R6 restore", memWdata, mem[reqAddr]);
      check(!refreshWrap, "R8 no refresh", refreshWrap, 0);
    end else begin
      check(decAddr == int'(expRef), "R7 refresh addr", decAddr, expRef);
      check(memWrStrobe && memWdata == mem[decAddr], "R7 refresh restore", memWdata, mem[decAddr]);
      check(refreshWrap == (expRef == 9'd511), "R9 wrap", refreshWrap, expRef == 9'd511);
      if (refreshWrap) wrapsSeen++;
      expRef = expRef + 1'b1;
    end
    if (rspValid) begin
      if (rspQ.size() == 0) check(0, "R4 unexpected rsp", 1, 0);
      else begin
        e = rspQ.pop_front();
        check(rspData == e[15:0], "R4 rdata", rspData, e[15:0]);
        check(rspParErr == e[16], "R5 parerr", rspParErr, e[16]);
      end
    end else check(!rspParErr, "R5 err without rsp", rspParErr, 0);
  end

  task automatic doReq(input bit wr, input logic [8:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    if (!wr) rspQ.push_back({perr(mem[a]), mem[a][15:0]});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; reqValid = 1'b0;
    end
  endtask

  task automatic corrupt(input logic [8:0] a, input int b);
    @(posedge clk); #1; reqValid = 1'b0;
    mem[a][b] = ~mem[a][b];
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2);
    // R1: state during reset
    check(!reqReady && !rspValid && !rspParErr && !memWrStrobe, "R1 reset outputs",
          {reqReady, rspValid, memWrStrobe}, 0);
    check(memRowSel == 0 && memColSel == 0, "R1 reset selects", memRowSel, 0);
    @(posedge clk); #1; rstN = 1'b1;
    #(CLK_PERIOD/2 - 1);
    check(!reqReady && !memWrStrobe, "R1 first cycle after reset", reqReady, 0);
    @(posedge clk); #1;
    check(reqReady, "R1 ready", reqReady, 1);
    monOn = 1'b1;

    // Writes and read-backs (R2, R3, R4, R6)
    doReq(1, 9'd0,   16'h0001);
    doReq(1, 9'd511, 16'hA5C3);
    doReq(1, 9'd77,  16'hFF00);
    doReq(0, 9'd511, 16'h0);
    doReq(0, 9'd0,   16'h0);
    doReq(1, 9'd300, 16'h1234);
    doReq(0, 9'd300, 16'h0);   // read right after write
    doReq(0, 9'd300, 16'h0);   // restore kept the word
    doReq(0, 9'd77,  16'h0);
    idle(3);

    // Parity faults (R5)
    doReq(1, 9'd5, 16'h00F0);
    doReq(1, 9'd9, 16'h8001);
    doReq(1, 9'd12, 16'h3C3C);
    corrupt(9'd5, 3);            // single data bit, byte 0
    corrupt(9'd9, 17);           // stored parity of byte 1
    corrupt(9'd12, 0);
    corrupt(9'd12, 1);           // two bits in one byte: parity still even
    doReq(0, 9'd5, 16'h0);
    doReq(0, 9'd9, 16'h0);
    doReq(0, 9'd12, 16'h0);
    doReq(0, 9'd5, 16'h0);       // error persists after restore
    idle(2);

    // Long burst: refresh stalls, then resumes in place (R8)
    for (int i = 0; i < 40; i++) doReq(i[0], 9'(i * 13), 16'(i * 16'h0101));
    idle(4);

    // Full passes: wrap on 511 only (R7, R9)
    idle(1100);
    check(wrapsSeen >= 2, "R9 wraps per pass", wrapsSeen, 2);
    doReq(0, 9'd77, 16'h0);
    idle(2);
    check(rspQ.size() == 0, "R4 all responses seen", rspQ.size(), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule